// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a segment and offset pair into a 20-bit linear memory address, in the way a 16-bit real-mode processor does. It keeps four 16-bit segment registers: code, data, extra and stack. A write port loads them. Each access request carries an access kind, an optional segment override and a 16-bit offset. The block picks one segment register and shifts its value left by one nibble, filling the low four bits with zeros. It then adds the offset and drops any carry beyond bit 19.

The result is registered. A valid strobe marks the cycle after each request. Register loads are synchronous, and a request always sees the register contents from before any write in the same cycle. It has no limit checks, no protection and no bus handshake.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset the code segment register holds FFFFh, and the data, extra and stack registers hold 0000h. addr_valid is low and addr is 00000h.
- R2: Segment indices are 0 = code, 1 = data, 2 = extra and 3 = stack. When wr_en is high on a clock edge, the register at index wr_sel takes wr_data from that edge on.
- R3: A request in the same cycle as a write to the segment register it selects uses the value from before the write.
- R4: Access kind 00 is an instruction fetch. It always uses the code segment, whatever ovr_en and ovr_sel hold.
- R5: Without an override, access kinds 01 and 11 (data) use the data segment, and kind 10 (stack) uses the stack segment.
- R6: For any access kind other than 00, ovr_en high selects the segment register given by ovr_sel.
- R7: addr equals the selected segment value times 16 plus offset, taken modulo 2^20. For example, FFFFh:0010h gives 00000h.
- R8: addr_valid is high exactly in the cycle after a request strobe. While no request arrives, addr keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Index of the segment register to write |
| wr_data | input | 16 | Value to load |
| req | input | 1 | Address request strobe |
| req_kind | input | 2 | Access kind: 00 fetch, 01/11 data, 10 stack |
| ovr_en | input | 1 | Segment override enable (ignored for fetches) |
| ovr_sel | input | 2 | Segment register index used when the override applies |
| offset | input | 16 | Offset within the segment |
| addr | output | 20 | Registered linear address |
| addr_valid | output | 1 | High for the cycle after a request |

## Verification
The assertions assume the request and write inputs hold steady across each rising edge. They also assume that req_kind, ovr_sel and wr_sel carry defined values whenever their strobes are high. The bench drives every input on the falling edge and leaves the selectors at known values between requests, so nothing changes near a sampling edge. The stimulus covers all four kinds and every override index. It includes an offset that carries past bit 19, and a write and a request to the same register in one cycle. The checker compares the fetch address with the code register value from the previous cycle, so a write that lands together with a fetch stays inside the property.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int NSEG = 4,
  parameter logic [SEG_W-1:0] CODE_RESET = 16'hFFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic [$clog2(NSEG)-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic req,
  input  logic [1:0] req_kind,
  input  logic ovr_en,
  input  logic [$clog2(NSEG)-1:0] ovr_sel,
  input  logic [OFF_W-1:0] offset,
  output logic [SEG_W+SHIFT-1:0] addr,
  output logic addr_valid
);
  localparam int ADDR_W = SEG_W + SHIFT;
  localparam int SEL_W = $clog2(NSEG);
  localparam logic [SEL_W-1:0] IDX_CODE = 0;
  localparam logic [SEL_W-1:0] IDX_DATA = 1;
  localparam logic [SEL_W-1:0] IDX_STACK = 3;
  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_STACK = 2'b10;

  logic [NSEG-1:0][SEG_W-1:0] segs;
  logic [SEL_W-1:0] use_sel;
  logic [ADDR_W-1:0] lin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++)
        segs[i] <= (i == int'(IDX_CODE)) ? CODE_RESET : '0;
    end else if (wr_en) begin
      segs[wr_sel] <= wr_data;
    end
  end

  assign use_sel = (req_kind == KIND_FETCH) ? IDX_CODE :
                   ovr_en                   ? ovr_sel :
                   (req_kind == KIND_STACK) ? IDX_STACK : IDX_DATA;

  assign lin = ({{(ADDR_W-SEG_W){1'b0}}, segs[use_sel]} << SHIFT)
             + {{(ADDR_W-OFF_W){1'b0}}, offset};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= req;
      if (req) addr <= lin;
    end
  end
endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic [1:0] wr_sel,
  input logic [15:0] wr_data,
  input logic req,
  input logic [1:0] req_kind,
  input logic [15:0] offset,
  input logic [19:0] addr,
  input logic addr_valid,
  input logic [3:0][15:0] segs
);
  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid == $past(req));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(addr));

  // R2
  seg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> segs[$past(wr_sel)] == $past(wr_data));

  // R4
  fetch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_kind == 2'b00) |=>
      addr == (({4'b0, $past(segs[0])} << 4) + {4'b0, $past(offset)}));
endmodule

bind seg_addr_gen seg_addr_chk chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .req(req), .req_kind(req_kind), .offset(offset),
  .addr(addr), .addr_valid(addr_valid), .segs(segs)
);

// File: tb/seg_addr_gen_test.sv
`timescale 1ns/1ps
module seg_addr_gen_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, req = 0, ovr_en = 0;
  logic [1:0] wr_sel = 0, req_kind = 0, ovr_sel = 0;
  logic [15:0] wr_data = 0, offset = 0;
  logic [19:0] addr;
  logic addr_valid;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  seg_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req(req), .req_kind(req_kind), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .offset(offset), .addr(addr), .addr_valid(addr_valid)
  );

  // {kind[2], ovr_en, ovr_sel[2], offset[16], expected[20]}
  // segments: code 4000h, data 1000h, extra 2000h, stack 3000h
  localparam logic [40:0] VEC [9] = '{
    {2'b00, 1'b0, 2'd0, 16'h0005, 20'h40005}, // R4
    {2'b00, 1'b1, 2'd1, 16'h0005, 20'h40005}, // R4 override ignored
    {2'b01, 1'b0, 2'd0, 16'h0234, 20'h10234}, // R5
    {2'b10, 1'b0, 2'd0, 16'hFFFE, 20'h3FFFE}, // R5
    {2'b01, 1'b1, 2'd2, 16'h0001, 20'h20001}, // R6
    {2'b01, 1'b1, 2'd3, 16'h0010, 20'h30010}, // R6
    {2'b10, 1'b1, 2'd0, 16'h0000, 20'h40000}, // R6
    {2'b11, 1'b1, 2'd1, 16'hFFFF, 20'h1FFFF}, // R6 R7
    {2'b11, 1'b0, 2'd0, 16'h0100, 20'h10100}  // R5
  };

  task automatic check(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_req(input logic [1:0] k, input logic oe, input logic [1:0] os,
                        input logic [15:0] off, input logic [19:0] exp, input string tag);
    @(negedge clk); req = 1; req_kind = k; ovr_en = oe; ovr_sel = os; offset = off;
    @(negedge clk); req = 0; ovr_en = 0;
    check(addr == exp, tag, addr, exp);
    check(addr_valid == 1'b1, {tag, " valid (R8)"}, {19'b0, addr_valid}, 20'h1);
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(addr == 20'h0 && !addr_valid, "R1 reset outputs", addr, 20'h0);
    rst_n = 1;
    do_req(2'b00, 0, 0, 16'h0000, 20'hFFFF0, "R1 code reset value");
    do_req(2'b01, 0, 0, 16'h0000, 20'h00000, "R1 data reset value");
    do_req(2'b01, 1, 2, 16'h0000, 20'h00000, "R1 extra reset value");
    do_req(2'b10, 0, 0, 16'h0000, 20'h00000, "R1 stack reset value");
    do_req(2'b00, 0, 0, 16'h0010, 20'h00000, "R7 wrap FFFF:0010");

    wr(2'd0, 16'h4000); wr(2'd1, 16'h1000); wr(2'd2, 16'h2000); wr(2'd3, 16'h3000);
    for (int i = 0; i < 9; i++)
      do_req(VEC[i][40:39], VEC[i][38], VEC[i][37:36], VEC[i][35:20], VEC[i][19:0],
             $sformatf("R2 R4 R5 R6 vector %0d", i));

    // R8: idle cycles leave addr and drop valid
    @(negedge clk); @(negedge clk);
    check(addr == 20'h10100, "R8 addr hold", addr, 20'h10100);
    check(!addr_valid, "R8 valid low idle", {19'b0, addr_valid}, 20'h0);

    // R7 wrap through data segment
    wr(2'd1, 16'hFFFF);
    do_req(2'b01, 0, 0, 16'h0020, 20'h00010, "R7 data wrap");

    // R3: same-cycle write and request
    @(negedge clk); wr_en = 1; wr_sel = 2'd1; wr_data = 16'h0ABC;
    req = 1; req_kind = 2'b01; offset = 16'h0000;
    @(negedge clk); wr_en = 0; req = 0;
    check(addr == 20'hFFFF0, "R3 old value used", addr, 20'hFFFF0);
    do_req(2'b01, 0, 0, 16'h0000, 20'h0ABC0, "R2 new value visible");

    // R1: reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check(addr == 20'h0 && !addr_valid, "R1 reset clears outputs", addr, 20'h0);
    rst_n = 1;
    do_req(2'b00, 1, 2, 16'h0001, 20'hFFFF1, "R1 R4 code back to FFFF");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule